// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one byte per accepted request into an asynchronous serial frame on a single transmit line. A line that is not sending rests at logic high. A frame opens with a low start bit, carries between five and eight data bits with the least significant bit first, and closes with a high stop period. Bit timing comes from a baud tick supplied from outside at sixteen times the bit rate. Each start and data bit occupies sixteen ticks.

Two format inputs set the frame shape. A 2-bit word-length code picks the number of data bits. A 1-bit stop-select picks between the short stop period and the long one. The long stop lasts two bit times for 6, 7 or 8 data bits and one and a half bit times for 5 data bits. Both fields, and the data byte, are captured when a request is accepted and are held until that frame ends. The caller can therefore change them while a frame is on the line.

The controller is a four-state machine. `ST_IDLE` holds the line high and offers ready. On valid it takes the accept transition to `ST_START`, which drives the line low. When the start bit ends it moves to `ST_DATA`, which shifts out data bits. After the last data bit ends it moves to `ST_STOP`, which holds the line high. When the stop period ends it returns to `ST_IDLE`.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, busy is low and ready is high.
- R2: Word-length code 0, 1, 2 or 3 sends 5, 6, 7 or 8 data bits, least significant bit first, each bit held for 16 baud ticks.
- R3: An accepted frame begins with the line low for exactly 16 baud ticks, starting on the clock edge after the accept.
- R4: Stop-select 0 holds the line high for 16 baud ticks after the last data bit.
- R5: Stop-select 1 with word-length code 1, 2 or 3 holds the line high for 32 baud ticks.
- R6: Stop-select 1 with word-length code 0 holds the line high for 24 baud ticks.
- R7: Data bits above the selected word length have no effect: the stop level follows the last selected bit directly.
- R8: Data and format are captured when ready and valid are both high at a clock edge. Changes to them during the frame do not alter it.
- R9: Busy is high and ready is low from the edge after an accept until the edge that counts the last stop tick. At that edge busy falls and ready rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Request to send tx_data |
| tx_ready | output | 1 | High when a request can be accepted |
| wlen_sel | input | 2 | Word-length code, 0..3 gives 5..8 data bits |
| stop_sel | input | 1 | Stop select, 0 short, 1 long |
| tx_line | output | 1 | Serial transmit line, idle high |
| tx_busy | output | 1 | High while a frame is being sent |

## Verification
Frames are sent with every word-length code and both stop settings. Comparing line length between cases separates the 16-, 24- and 32-tick stop periods, and the 5-bit long-stop case separates the half-bit rule from the two-bit rule. Byte values with alternating and asymmetric bit patterns expose bit-order and shift errors. A 5-bit frame whose upper three bits are set checks that unselected bits never reach the line. After every accept the bench inverts the data and format inputs, so a design that reads them live rather than from its captured copy sends a visibly different frame.

// File: rtl/uart_frame_pkg.sv
`timescale 1ns/1ps
package uart_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       long_stop;
    } tx_fmt_t;

endpackage

// File: rtl/utx_fmt_decode.sv
`timescale 1ns/1ps
// Turns the captured format into a data-bit count and a stop length in ticks.
module utx_fmt_decode
    import uart_frame_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int CNT_W      = 6,
    parameter int IDX_W      = 4
) (
    input  tx_fmt_t          fmt,
    output logic [IDX_W-1:0] nbits,
    output logic [CNT_W-1:0] stop_ticks
);
    localparam logic [CNT_W-1:0] STOP_ONE  = CNT_W'(OVERSAMPLE);
    localparam logic [CNT_W-1:0] STOP_HALF = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2);
    localparam logic [CNT_W-1:0] STOP_TWO  = CNT_W'(2 * OVERSAMPLE);

    always_comb begin
        nbits = IDX_W'(5) + IDX_W'(fmt.wlen);
        if (!fmt.long_stop) begin
            stop_ticks = STOP_ONE;
        end else if (fmt.wlen == 2'd0) begin
            stop_ticks = STOP_HALF;
        end else begin
            stop_ticks = STOP_TWO;
        end
    end
endmodule

// File: rtl/utx_tick_cnt.sv
`timescale 1ns/1ps
// Counts baud ticks inside one bit or stop period. Flags the final tick.
module utx_tick_cnt #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    assign last = tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
    import uart_frame_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [1:0]        wlen_sel,
    input  logic              stop_sel,
    output logic              tx_line,
    output logic              tx_busy
);
    localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
    localparam int IDX_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(OVERSAMPLE);

    tx_state_e         state_q, state_d;
    tx_fmt_t           fmt_q;
    logic [DATA_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  nbits;
    logic [CNT_W-1:0]  stop_ticks;
    logic [CNT_W-1:0]  period;
    logic              period_end;
    logic              accept;
    logic              last_data;

    utx_fmt_decode #(
        .OVERSAMPLE (OVERSAMPLE),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W)
    ) u_decode (
        .fmt        (fmt_q),
        .nbits      (nbits),
        .stop_ticks (stop_ticks)
    );

    assign period = (state_q == ST_STOP) ? stop_ticks : BIT_TICKS;

    utx_tick_cnt #(
        .CNT_W (CNT_W)
    ) u_ticks (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .tick  (baud_tick),
        .limit (period),
        .last  (period_end)
    );

    assign accept    = tx_valid && (state_q == ST_IDLE);
    assign last_data = (idx_q == nbits - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_valid)                state_d = ST_START;
            ST_START: if (period_end)              state_d = ST_DATA;
            ST_DATA:  if (period_end && last_data) state_d = ST_STOP;
            ST_STOP:  if (period_end)              state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame capture and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q   <= '0;
            shreg_q <= '0;
            idx_q   <= '0;
        end else if (accept) begin
            fmt_q   <= '{wlen: wlen_sel, long_stop: stop_sel};
            shreg_q <= tx_data;
            idx_q   <= '0;
        end else if (state_q == ST_DATA && period_end) begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx_line  = 1'b1;
        tx_busy  = 1'b1;
        tx_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tx_busy  = 1'b0;
                tx_ready = 1'b1;
            end
            ST_START: tx_line = 1'b0;
            ST_DATA:  tx_line = shreg_q[0];
            ST_STOP:  tx_line = 1'b1;
            default:  tx_line = 1'b1;
        endcase
    end
endmodule

// File: rtl/utx_checker.sv
`timescale 1ns/1ps
module utx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_busy,
    input logic       tx_line,
    input logic [2:0] fmt_bits
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line); // R3

    AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy) && !$past(baud_tick)) |-> $stable(tx_line)); // R2

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (tx_busy && !tx_ready)); // R9

    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> ($past(baud_tick) && $past(tx_line))); // R4

    AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(fmt_bits)); // R8
endmodule

bind uart_frame_tx utx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_busy   (tx_busy),
    .tx_line   (tx_line),
    .fmt_bits  (fmt_q)
);

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
    typedef struct {
        logic [7:0] d;
        logic [1:0] w;
        logic       s;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic [1:0] wlen_sel = 2'd0;
    logic       stop_sel = 1'b0;
    logic       tx_ready, tx_line, tx_busy;

    int   checks = 0;
    int   fails = 0;
    int   frames_done = 0;
    bit   finished = 1'b0;
    bit   tick_en = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    uart_frame_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .wlen_sel  (wlen_sel),
        .stop_sel  (stop_sel),
        .tx_line   (tx_line),
        .tx_busy   (tx_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Baud tick every third clock, driven on the falling edge
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (tick_en) begin
                div = (div == 2) ? 0 : div + 1;
                baud_tick = (div == 2);
            end
        end
    end

    // Driver: request a frame, record what it should be, then disturb the inputs (R8)
    task automatic send(input logic [7:0] d, input logic [1:0] w, input logic s);
        exp_t it;
        @(negedge clk);
        tx_data  = d;
        wlen_sel = w;
        stop_sel = s;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        it.d = d; it.w = w; it.s = s;
        q.push_back(it);
        @(negedge clk);
        tx_valid = 1'b0;
        tx_data  = ~d;
        wlen_sel = ~w;
        stop_sel = ~s;
    endtask

    // Monitor: walk each frame tick by tick and compare against the popped item
    initial begin
        exp_t  it;
        int    n, st, tot, k, b, dend;
        string stag;
        wait (rst_n);
        forever begin
            @(negedge clk); #1;
            if (!tx_line) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected frame", 0, 1);
                end else begin
                    it   = q.pop_front();
                    n    = 5 + int'(it.w);
                    st   = it.s ? ((it.w == 2'd0) ? 24 : 32) : 16;
                    stag = it.s ? ((it.w == 2'd0) ? "R6 stop length" : "R5 stop length") : "R4 stop length";
                    dend = 16 * (1 + n);
                    tot  = dend + st;
                    k    = 0;
                    while (k < tot) begin
                        if (baud_tick) begin
                            if (k == 8) begin
                                chk(tx_line == 1'b0, "R3 start bit", int'(tx_line), 0);
                                chk(tx_busy && !tx_ready, "R9 busy during frame", int'(tx_busy), 1);
                            end else if (k < dend && (k % 16) == 8) begin
                                b = (k / 16) - 1;
                                chk(tx_line == it.d[b], "R2 data bit", int'(tx_line), int'(it.d[b]));
                            end else if (k == dend + 8) begin
                                chk(tx_line == 1'b1, "R7 stop after last selected bit", int'(tx_line), 1);
                            end
                            if (k == tot - 1) begin
                                chk(tx_line && !tx_ready, stag, int'(tx_ready), 0);
                            end
                            k++;
                        end
                        if (k < tot) begin
                            @(negedge clk); #1;
                        end
                    end
                    @(negedge clk); #1;
                    chk(tx_ready && !tx_busy && tx_line, stag, int'(tx_ready), 1);
                    chk(tx_ready && !tx_busy, "R9 ready after last stop tick", int'(tx_ready), 1);
                    chk(tx_ready, "R8 frame kept captured format", int'(tx_ready), 1);
                    frames_done++;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d frames expected %0d", frames_done, 8);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(tx_line == 1'b1, "R1 idle line", int'(tx_line), 1);
        chk(tx_busy == 1'b0, "R1 idle busy", int'(tx_busy), 0);
        chk(tx_ready == 1'b1, "R1 idle ready", int'(tx_ready), 1);
        tick_en = 1'b1;

        send(8'hA5, 2'd3, 1'b0);   // R2 8 bits, R4
        send(8'hE0, 2'd0, 1'b0);   // R7 upper bits set, 5 bits
        send(8'hF3, 2'd0, 1'b1);   // R6 1.5 stop
        send(8'hC6, 2'd1, 1'b1);   // R5 6 bits
        send(8'h3C, 2'd2, 1'b1);   // R5 7 bits
        send(8'h81, 2'd3, 1'b1);   // R5 8 bits
        send(8'h55, 2'd2, 1'b0);   // R2 7 bits, R4
        send(8'hDA, 2'd1, 1'b0);   // R2 6 bits, R4

        wait (frames_done == 8);
        repeat (5) @(posedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule